// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is a byte-wide parallel printer port behind a small synchronous register interface. The CPU writes a data register that drives the eight port lines. It also writes a control register. That register asserts the four active-low open-drain handshake lines to the printer (strobe, autofeed, initialize, select-in) and holds a port direction bit and an interrupt enable. The printer's busy, paper-empty, selected, error and acknowledge inputs arrive asynchronously. Each one passes through a two-flop synchronizer before it is sampled into a status register.

A print-complete flag is set on the rising edge of the synchronized acknowledge and is cleared by a status read. A mode pin picks the interrupt source: either the synchronized acknowledge itself, or the latched print-complete flag. A second pin picks the data-line direction: either always driving, or driving under control of the direction bit.

Pad behaviour is brought out as output-enable signals. An open-drain handshake line pulls low while its enable is high. The data lines and the interrupt are tri-stated while their enables are low.

Top module: `ppc_top`

## Requirements
- R1: After reset the data register, control register and rdata_o are all zero. hs_oe_o and irq_oe_o are low, so every handshake line is released and the interrupt is in high impedance.
- R2: A write with sel_i and wr_i at address 0 loads the data register, and pd_o shows the value from the next cycle.
- R3: A write at address 2 loads the control register. Bits 0, 1, 2 and 3 drive hs_oe_o[0] (strobe), hs_oe_o[1] (autofeed), hs_oe_o[2] (initialize) and hs_oe_o[3] (select-in); a 1 pulls that line low. Reading address 2 returns bits 5:0 of the written value, with bits 7:6 read as zero.
- R4: When enh_mode_i is low, pd_oe_o is high whatever the direction bit holds. When enh_mode_i is high, pd_oe_o is the inverse of control bit 5 (1 = receive).
- R5: A read of address 1 returns the status byte. Bit 5 is busy, bit 4 paper-empty, bit 3 selected, bit 2 the active-low error input as sampled, bit 1 acknowledge and bit 0 print-complete. Bits 7:6 read as zero. Each input shows up two clock edges after it changes.
- R6: The print-complete flag is set by a rising edge of the synchronized acknowledge. A falling edge does not set it.
- R7: A status read returns the print-complete flag as it stood before the read and clears it. If a rising edge arrives in the same cycle, the set wins.
- R8: irq_oe_o equals control bit 4.
- R9: With irq_mode_i low, irq_o follows the synchronized acknowledge.
- R10: With irq_mode_i high, irq_o follows the print-complete flag. It stays high after acknowledge falls and drops after a status read.
- R11: A read of address 0 returns pd_i while pd_oe_o is low, and returns the data register while pd_oe_o is high.
- R12: A write or read with sel_i low changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered on the read cycle |
| pd_i | input | 8 | Port data lines as seen at the pads |
| pd_o | output | 8 | Port data driven from the data register |
| pd_oe_o | output | 1 | Port data output enable |
| hs_oe_o | output | 4 | Open-drain pull-down enables: strobe, autofeed, initialize, select-in |
| busy_i | input | 1 | Printer not ready when high |
| pe_i | input | 1 | Paper empty when high |
| slct_i | input | 1 | Printer selected when high |
| err_ni | input | 1 | Printer error when low |
| ack_i | input | 1 | Printer acknowledge |
| irq_mode_i | input | 1 | Interrupt source: 0 acknowledge, 1 print-complete flag |
| enh_mode_i | input | 1 | 0 fixed output direction, 1 direction from control bit 5 |
| irq_o | output | 1 | Interrupt level |
| irq_oe_o | output | 1 | Interrupt output enable |

## Verification
The properties assume that a register access lasts exactly one cycle. They also assume that the mode pins and the printer lines change only away from the active edge. The acknowledge property further assumes that ack_i holds for three edges before irq_o is compared with it. To stay within this, the stimulus drives every input at the falling edge and holds each printer line for at least three cycles before it samples. It issues wr_i and rd_i as single-cycle pulses and changes irq_mode_i only while acknowledge is idle.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int CW = 6;

  localparam logic [AW-1:0] A_DATA = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_CTRL = 2'd2;

  localparam int C_IE  = 4;
  localparam int C_DIR = 5;

  typedef struct packed {
    logic ack;
    logic err_n;
    logic slct;
    logic pe;
    logic busy;
  } prn_in_t;

  localparam int PRN_W = $bits(prn_in_t);
endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= stg[i-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ppc_regs.sv
module ppc_regs
  import ppc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pd_i,
  input  logic          enh_mode_i,
  input  logic [DW-1:0] stat_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] data_q_o,
  output logic [CW-1:0] ctrl_q_o,
  output logic          pd_oe_o,
  output logic          stat_rd_o
);
  logic          wr_en, rd_en;
  logic [DW-1:0] rmux;

  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & rd_i;
  assign stat_rd_o = rd_en && (addr_i == A_STAT);

  // direction bit only honoured in enhanced mode; 1 means receive
  assign pd_oe_o = ~enh_mode_i | ~ctrl_q_o[C_DIR];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      data_q_o <= '0;
      ctrl_q_o <= '0;
    end else if (wr_en) begin
      if (addr_i == A_DATA) data_q_o <= wdata_i;
      if (addr_i == A_CTRL) ctrl_q_o <= wdata_i[CW-1:0];
    end

  always_comb begin
    unique case (addr_i)
      A_DATA:  rmux = pd_oe_o ? data_q_o : pd_i;
      A_STAT:  rmux = stat_i;
      A_CTRL:  rmux = {{(DW-CW){1'b0}}, ctrl_q_o};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rmux;
endmodule

// File: rtl/ppc_irq.sv
module ppc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_s_i,
  input  logic stat_rd_i,
  input  logic irq_mode_i,
  output logic done_o,
  output logic irq_o
);
  logic ack_q, ack_rise;

  assign ack_rise = ack_s_i & ~ack_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      ack_q <= ack_s_i;
      // a new edge beats a concurrent clearing read
      if (ack_rise)       done_o <= 1'b1;
      else if (stat_rd_i) done_o <= 1'b0;
    end

  assign irq_o = irq_mode_i ? done_o : ack_s_i;
endmodule

// File: rtl/ppc_top.sv
module ppc_top
  import ppc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  output logic [3:0]    hs_oe_o,
  input  logic          busy_i,
  input  logic          pe_i,
  input  logic          slct_i,
  input  logic          err_ni,
  input  logic          ack_i,
  input  logic          irq_mode_i,
  input  logic          enh_mode_i,
  output logic          irq_o,
  output logic          irq_oe_o
);
  prn_in_t       prn_raw, prn_s;
  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] stat;
  logic          stat_rd, done;

  assign prn_raw = '{ack: ack_i, err_n: err_ni, slct: slct_i, pe: pe_i, busy: busy_i};

  ppc_sync #(.W(PRN_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (prn_raw),
    .q_o   (prn_s)
  );

  assign stat = {2'b00, prn_s.busy, prn_s.pe, prn_s.slct, prn_s.err_n, prn_s.ack, done};

  ppc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pd_i      (pd_i),
    .enh_mode_i(enh_mode_i),
    .stat_i    (stat),
    .rdata_o   (rdata_o),
    .data_q_o  (pd_o),
    .ctrl_q_o  (ctrl_q),
    .pd_oe_o   (pd_oe_o),
    .stat_rd_o (stat_rd)
  );

  ppc_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_s_i   (prn_s.ack),
    .stat_rd_i (stat_rd),
    .irq_mode_i(irq_mode_i),
    .done_o    (done),
    .irq_o     (irq_o)
  );

  assign hs_oe_o  = ctrl_q[3:0];
  assign irq_oe_o = ctrl_q[C_IE];
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] pd_o,
  input logic [3:0] hs_oe_o,
  input logic       ack_i,
  input logic       irq_mode_i,
  input logic       irq_o,
  input logic       irq_oe_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  p_data_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == 2'd0) |=> pd_o == $past(wdata_i));

  p_hs_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == 2'd2) |=> hs_oe_o == $past(wdata_i[3:0]));

  p_irq_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == 2'd2) |=> irq_oe_o == $past(wdata_i[4]));

  p_ack_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && !irq_mode_i && $stable(ack_i) && $past($stable(ack_i)))
      |-> irq_o == ack_i);

  p_unsel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(pd_o) && $stable(hs_oe_o) && $stable(irq_oe_o));
endmodule

bind ppc_top ppc_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pd_o      (pd_o),
  .hs_oe_o   (hs_oe_o),
  .ack_i     (ack_i),
  .irq_mode_i(irq_mode_i),
  .irq_o     (irq_o),
  .irq_oe_o  (irq_oe_o)
);

// File: tb/ppc_top_test.sv
`timescale 1ns/1ps
module ppc_top_test;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       sel_i = 0, wr_i = 0, rd_i = 0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o, pd_i = '0, pd_o;
  logic       pd_oe_o, irq_o, irq_oe_o;
  logic [3:0] hs_oe_o;
  logic       busy_i = 0, pe_i = 0, slct_i = 0, err_ni = 1, ack_i = 0;
  logic       irq_mode_i = 0, enh_mode_i = 0;
  int         n_run = 0, n_fail = 0;
  logic [7:0] r;

  always #2.5 clk_i = ~clk_i;

  ppc_top uut (.*);

  // {wdata[14:7], enh[6], exp_hs[5:2], exp_irq_oe[1], exp_pd_oe[0]}
  localparam logic [14:0] VEC [6] = '{
    {8'h01, 1'b0, 4'b0001, 1'b0, 1'b1},
    {8'h0A, 1'b0, 4'b1010, 1'b0, 1'b1},
    {8'h30, 1'b1, 4'b0000, 1'b1, 1'b0},
    {8'h1F, 1'b1, 4'b1111, 1'b1, 1'b1},
    {8'h20, 1'b0, 4'b0000, 1'b0, 1'b1},
    {8'hE4, 1'b1, 4'b0100, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic s = 1'b1);
    @(negedge clk_i); sel_i = s; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); sel_i = 0; wr_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); sel_i = 1; rd_i = 1; addr_i = a;
    @(negedge clk_i); sel_i = 0; rd_i = 0; d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 hs_oe", {4'h0, hs_oe_o}, 8'h00);
    chk("R1 irq_oe", {7'h0, irq_oe_o}, 8'h00);
    chk("R1 pd_o", pd_o, 8'h00);
    chk("R1 rdata", rdata_o, 8'h00);
    rd(2'd2, r); chk("R1 ctrl", r, 8'h00);

    // table walk: R3, R4, R8
    for (int i = 0; i < 6; i++) begin
      enh_mode_i = VEC[i][6];
      wr(2'd2, VEC[i][14:7]);
      chk("R3 hs_oe", {4'h0, hs_oe_o}, {4'h0, VEC[i][5:2]});
      chk("R8 irq_oe", {7'h0, irq_oe_o}, {7'h0, VEC[i][1]});
      chk("R4 pd_oe", {7'h0, pd_oe_o}, {7'h0, VEC[i][0]});
      rd(2'd2, r); chk("R3 readback", r, VEC[i][14:7] & 8'h3F);
    end

    // R2 data register
    enh_mode_i = 0;
    wr(2'd0, 8'hA5); chk("R2 pd_o", pd_o, 8'hA5);
    wr(2'd0, 8'h3C); chk("R2 pd_o", pd_o, 8'h3C);

    // R5 status sampling
    busy_i = 1; pe_i = 0; slct_i = 1; err_ni = 0; wait_cyc(3);
    rd(2'd1, r); chk("R5 status", r, 8'h28);
    busy_i = 0; pe_i = 1; slct_i = 0; err_ni = 1; wait_cyc(3);
    rd(2'd1, r); chk("R5 status", r, 8'h14);

    // R6, R7 print-complete flag
    ack_i = 1; wait_cyc(4);
    rd(2'd1, r); chk("R6 rise sets flag", r, 8'h17);
    rd(2'd1, r); chk("R7 read clears flag", r, 8'h16);
    ack_i = 0; wait_cyc(4);
    rd(2'd1, r); chk("R6 fall no set", r, 8'h14);

    // R9 direct acknowledge mode
    wr(2'd2, 8'h10);
    irq_mode_i = 0;
    ack_i = 1; wait_cyc(3); chk("R9 irq follows ack high", {7'h0, irq_o}, 8'h01);
    ack_i = 0; wait_cyc(3); chk("R9 irq follows ack low", {7'h0, irq_o}, 8'h00);

    // R10 latched mode
    irq_mode_i = 1;
    rd(2'd1, r); @(negedge clk_i);
    chk("R10 irq after clear", {7'h0, irq_o}, 8'h00);
    ack_i = 1; wait_cyc(4); chk("R10 irq set", {7'h0, irq_o}, 8'h01);
    ack_i = 0; wait_cyc(4); chk("R10 irq held", {7'h0, irq_o}, 8'h01);
    rd(2'd1, r); chk("R10 irq cleared by read", {7'h0, irq_o}, 8'h00);
    irq_mode_i = 0;

    // R11 data read
    enh_mode_i = 1; pd_i = 8'h5A;
    wr(2'd2, 8'h20);
    rd(2'd0, r); chk("R11 read pads", r, 8'h5A);
    wr(2'd2, 8'h00);
    rd(2'd0, r); chk("R11 read data reg", r, 8'h3C);

    // R12 unselected accesses
    wr(2'd2, 8'h13);
    wr(2'd2, 8'h0C, 1'b0);
    chk("R12 hs_oe kept", {4'h0, hs_oe_o}, 8'h03);
    chk("R12 irq_oe kept", {7'h0, irq_oe_o}, 8'h01);
    wr(2'd0, 8'hFF, 1'b0);
    chk("R12 pd_o kept", pd_o, 8'h3C);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule